// File: doc/BRIEF.md
# Fractional PLL Coefficient Calculator

This block works out the settings a fractional-N PLL needs in order to produce a requested output clock from a given reference clock. Both frequencies arrive as unsigned integers in hertz. A one-cycle start strobe launches a calculation. The block first chooses an output-divider setting, made of a 2-bit divide code and a postscale bit. The chosen setting must put the internal VCO-side frequency f2 (the target times the division factor) inside a 90 MHz to 100 MHz window. The block then divides f2 by the reference. It returns the whole part of that ratio as N and a 22-bit truncated fraction as K.

The divider setting comes from a fixed priority list of candidates, and all candidates are evaluated in a single cycle. The ratio comes from a restoring shift-subtract divider that yields one quotient bit per clock: first the integer bits, then the 22 fraction bits. A result is announced with a one-cycle done pulse. An error flag reports two cases: a zero reference, and a target that no divider setting can bring into the window. The outputs keep their last result until the next result is written.

Top module: `pll_coef_calc`

## Requirements
- R1: The divide code selects the base factor: 00 gives 2, 01 gives 4, 10 gives 8 and 11 gives 12. When the postscale bit is 1, the base factor is doubled, so the four codes give 4, 8, 16 and 24.
- R2: The f2 band is 90,000,000 to 100,000,000 Hz, both ends included. Candidate settings are tried in a fixed order and the first one in band is taken. The order is (post 0, code 10) first. The rest then follow from the smallest factor to the largest, with postscale 0 ahead of postscale 1 when the factors are equal: (0,00), (0,01), (1,00), (1,01), (0,11), (1,10), (1,11).
- R3: On success, N equals floor(f2 / reference) and err is 0.
- R4: On success, K equals floor(2^22 * (f2 mod reference) / reference), which is truncated and not rounded.
- R5: If no candidate places f2 in band, the block raises done with err = 1. In that case N, K, the code and postscale are all 0.
- R6: A start with a zero reference gives done and err in the very next cycle, with N, K, the code and postscale all 0.
- R7: A start strobe that arrives while a calculation is in progress is ignored. It neither disturbs the running result nor produces an extra done.
- R8: Done lasts one cycle for each accepted start. The code, postscale, N, K and err change only in a done cycle and otherwise hold.
- R9: After reset, every output is 0.
- R10: A start raised in the same cycle as done is accepted as a new calculation.
- R11: With a 12,000,000 Hz reference and a 12,288,000 Hz target, the result is post 0, code 10, N = 8 and K = 0xC49BA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled when idle |
| ref_hz_i | input | 32 | Reference frequency in Hz |
| tgt_hz_i | input | 32 | Target output frequency in Hz |
| mode_o | output | 2 | Divide code |
| post_o | output | 1 | Postscale bit |
| n_o | output | 27 | Integer multiplier N |
| k_o | output | 22 | Fractional multiplier K |
| done_o | output | 1 | One-cycle result pulse |
| err_o | output | 1 | Error flag, valid from a done cycle on |

## Verification
The done pulse of one calculation and the acceptance of the next start can fall in the same cycle. The bench raises start with fresh frequencies in exactly the cycle where done is seen high. It then expects the second calculation to run and to return that second pair's own results, while the first result was already intact in the done cycle. A second overlap is a start that lands while the divider is busy. That start carries a zero reference, which would force an immediate error if it were accepted. The check is that the running result comes out unchanged and that no extra done follows.

// File: rtl/pll_coef_pkg.sv
package pll_coef_pkg;

  localparam int NUM_CAND = 8;

  typedef struct packed {
    logic       post;
    logic [1:0] mode;
  } div_sel_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEL  = 2'd1,
    ST_DIV  = 2'd2
  } calc_state_t;

  // priority order: default /8 first, then ascending factor, post 0 before post 1
  function automatic div_sel_t cand_sel(input int idx);
    div_sel_t s;
    case (idx)
      0:       s = div_sel_t'{post: 1'b0, mode: 2'b10};
      1:       s = div_sel_t'{post: 1'b0, mode: 2'b00};
      2:       s = div_sel_t'{post: 1'b0, mode: 2'b01};
      3:       s = div_sel_t'{post: 1'b1, mode: 2'b00};
      4:       s = div_sel_t'{post: 1'b1, mode: 2'b01};
      5:       s = div_sel_t'{post: 1'b0, mode: 2'b11};
      6:       s = div_sel_t'{post: 1'b1, mode: 2'b10};
      default: s = div_sel_t'{post: 1'b1, mode: 2'b11};
    endcase
    return s;
  endfunction

  function automatic logic [4:0] div_factor(input div_sel_t s);
    logic [4:0] base;
    case (s.mode)
      2'b00:   base = 5'd2;
      2'b01:   base = 5'd4;
      2'b10:   base = 5'd8;
      default: base = 5'd12;
    endcase
    return s.post ? (base << 1) : base;
  endfunction

endpackage

// File: rtl/pll_band_check.sv
module pll_band_check
  import pll_coef_pkg::*;
#(
  parameter int          FREQ_W  = 32,
  parameter int unsigned BAND_LO = 90_000_000,
  parameter int unsigned BAND_HI = 100_000_000,
  parameter int          F2_W    = 27,
  parameter int          IDX     = 0
) (
  input  logic [FREQ_W-1:0] tgt_i,
  output logic              hit_o,
  output div_sel_t          sel_o,
  output logic [F2_W-1:0]   f2_o
);
  localparam int P_W = FREQ_W + 5;
  localparam div_sel_t SEL = cand_sel(IDX);
  localparam logic [4:0] FAC = div_factor(SEL);

  logic [P_W-1:0] prod;

  assign prod  = P_W'(tgt_i) * P_W'(FAC);
  assign hit_o = (prod >= P_W'(BAND_LO)) && (prod <= P_W'(BAND_HI));
  assign sel_o = SEL;
  assign f2_o  = prod[F2_W-1:0];
endmodule

// File: rtl/pll_div_select.sv
module pll_div_select
  import pll_coef_pkg::*;
#(
  parameter int          FREQ_W  = 32,
  parameter int unsigned BAND_LO = 90_000_000,
  parameter int unsigned BAND_HI = 100_000_000,
  parameter int          F2_W    = 27
) (
  input  logic [FREQ_W-1:0] tgt_i,
  output logic              found_o,
  output div_sel_t          sel_o,
  output logic [F2_W-1:0]   f2_o
);
  logic [NUM_CAND-1:0] hit;
  div_sel_t            sel_a [NUM_CAND];
  logic [F2_W-1:0]     f2_a  [NUM_CAND];

  for (genvar g = 0; g < NUM_CAND; g++) begin : g_cand
    pll_band_check #(
      .FREQ_W (FREQ_W),
      .BAND_LO(BAND_LO),
      .BAND_HI(BAND_HI),
      .F2_W   (F2_W),
      .IDX    (g)
    ) u_chk (
      .tgt_i(tgt_i),
      .hit_o(hit[g]),
      .sel_o(sel_a[g]),
      .f2_o (f2_a[g])
    );
  end

  // lowest index wins
  always_comb begin
    found_o = 1'b0;
    sel_o   = '0;
    f2_o    = '0;
    for (int i = NUM_CAND - 1; i >= 0; i--) begin
      if (hit[i]) begin
        found_o = 1'b1;
        sel_o   = sel_a[i];
        f2_o    = f2_a[i];
      end
    end
  end
endmodule

// File: rtl/pll_frac_div.sv
module pll_frac_div #(
  parameter int FREQ_W = 32,
  parameter int F2_W   = 27,
  parameter int FRAC_W = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [F2_W-1:0]   f2_i,
  input  logic [FREQ_W-1:0] dvr_i,
  output logic              valid_o,
  output logic [F2_W+FRAC_W-1:0] quot_o
);
  localparam int Q_W   = F2_W + FRAC_W;
  localparam int CNT_W = $clog2(Q_W);

  logic [Q_W-1:0]    dvd_q;
  logic [Q_W-1:0]    quo_q;
  logic [FREQ_W-1:0] rem_q;
  logic [FREQ_W-1:0] dvr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              run_q;
  logic              valid_q;

  logic [FREQ_W:0]   trial;
  logic              ge;

  assign trial = {rem_q, dvd_q[Q_W-1]};
  assign ge    = trial >= {1'b0, dvr_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dvd_q   <= '0;
      quo_q   <= '0;
      rem_q   <= '0;
      dvr_q   <= '0;
      cnt_q   <= '0;
      run_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (load_i) begin
        dvd_q <= {f2_i, {FRAC_W{1'b0}}};
        quo_q <= '0;
        rem_q <= '0;
        dvr_q <= dvr_i;
        cnt_q <= CNT_W'(Q_W - 1);
        run_q <= 1'b1;
      end else if (run_q) begin
        dvd_q <= dvd_q << 1;
        quo_q <= {quo_q[Q_W-2:0], ge};
        rem_q <= ge ? FREQ_W'(trial - {1'b0, dvr_q}) : trial[FREQ_W-1:0];
        if (cnt_q == '0) begin
          run_q   <= 1'b0;
          valid_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign valid_o = valid_q;
  assign quot_o  = quo_q;
endmodule

// File: rtl/pll_coef_calc.sv
module pll_coef_calc
  import pll_coef_pkg::*;
#(
  parameter int          FREQ_W  = 32,
  parameter int          FRAC_W  = 22,
  parameter int unsigned BAND_LO = 90_000_000,
  parameter int unsigned BAND_HI = 100_000_000,
  localparam int         F2_W    = $clog2(BAND_HI + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [FREQ_W-1:0] ref_hz_i,
  input  logic [FREQ_W-1:0] tgt_hz_i,
  output logic [1:0]        mode_o,
  output logic              post_o,
  output logic [F2_W-1:0]   n_o,
  output logic [FRAC_W-1:0] k_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int Q_W = F2_W + FRAC_W;

  calc_state_t       state_q;
  logic [FREQ_W-1:0] ref_q;
  logic [FREQ_W-1:0] tgt_q;
  div_sel_t          sel_q;

  logic              busy_w;
  logic              in_div_w;
  logic              found_w;
  div_sel_t          sel_w;
  logic [F2_W-1:0]   f2_w;
  logic              div_load_w;
  logic              div_valid_w;
  logic [Q_W-1:0]    quot_w;

  assign busy_w     = (state_q != ST_IDLE);
  assign in_div_w   = (state_q == ST_DIV);
  assign div_load_w = (state_q == ST_SEL) && found_w;

  pll_div_select #(
    .FREQ_W (FREQ_W),
    .BAND_LO(BAND_LO),
    .BAND_HI(BAND_HI),
    .F2_W   (F2_W)
  ) u_sel (
    .tgt_i  (tgt_q),
    .found_o(found_w),
    .sel_o  (sel_w),
    .f2_o   (f2_w)
  );

  pll_frac_div #(
    .FREQ_W(FREQ_W),
    .F2_W  (F2_W),
    .FRAC_W(FRAC_W)
  ) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (div_load_w),
    .f2_i   (f2_w),
    .dvr_i  (ref_q),
    .valid_o(div_valid_w),
    .quot_o (quot_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ref_q   <= '0;
      tgt_q   <= '0;
      sel_q   <= '0;
      mode_o  <= '0;
      post_o  <= 1'b0;
      n_o     <= '0;
      k_o     <= '0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!busy_w) begin
        if (start_i) begin
          ref_q <= ref_hz_i;
          tgt_q <= tgt_hz_i;
          if (ref_hz_i == '0) begin
            done_o <= 1'b1;
            err_o  <= 1'b1;
            mode_o <= '0;
            post_o <= 1'b0;
            n_o    <= '0;
            k_o    <= '0;
          end else begin
            state_q <= ST_SEL;
          end
        end
      end else if (in_div_w) begin
        if (div_valid_w) begin
          done_o  <= 1'b1;
          err_o   <= 1'b0;
          mode_o  <= sel_q.mode;
          post_o  <= sel_q.post;
          n_o     <= quot_w[Q_W-1:FRAC_W];
          k_o     <= quot_w[FRAC_W-1:0];
          state_q <= ST_IDLE;
        end
      end else begin
        if (found_w) begin
          sel_q   <= sel_w;
          state_q <= ST_DIV;
        end else begin
          done_o  <= 1'b1;
          err_o   <= 1'b1;
          mode_o  <= '0;
          post_o  <= 1'b0;
          n_o     <= '0;
          k_o     <= '0;
          state_q <= ST_IDLE;
        end
      end
    end
  end
endmodule

// File: rtl/pll_coef_calc_chk.sv
module pll_coef_calc_chk #(
  parameter int FREQ_W = 32,
  parameter int F2_W   = 27,
  parameter int FRAC_W = 22
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [FREQ_W-1:0] ref_hz_i,
  input logic [1:0]        mode_o,
  input logic              post_o,
  input logic [F2_W-1:0]   n_o,
  input logic [FRAC_W-1:0] k_o,
  input logic              done_o,
  input logic              err_o,
  input logic              busy_w,
  input logic              in_div_w
);
  a_r6_zero_ref: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_w && start_i && ref_hz_i == '0) |=> (done_o && err_o && n_o == '0 && k_o == '0));

  a_r5_err_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (n_o == '0 && k_o == '0 && mode_o == 2'b00 && !post_o));

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable({mode_o, post_o, n_o, k_o, err_o}));

  a_r8_done_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(start_i) || $past(busy_w)));

  a_r7_busy_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_div_w && start_i) |=> !(done_o && err_o));
endmodule

bind pll_coef_calc pll_coef_calc_chk #(
  .FREQ_W(FREQ_W),
  .F2_W  (F2_W),
  .FRAC_W(FRAC_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .ref_hz_i(ref_hz_i),
  .mode_o  (mode_o),
  .post_o  (post_o),
  .n_o     (n_o),
  .k_o     (k_o),
  .done_o  (done_o),
  .err_o   (err_o),
  .busy_w  (busy_w),
  .in_div_w(in_div_w)
);

// File: tb/pll_coef_calc_tb.sv
module pll_coef_calc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] ref_hz = '0;
  logic [31:0] tgt_hz = '0;
  logic [1:0]  mode;
  logic        post;
  logic [26:0] n_val;
  logic [21:0] k_val;
  logic        done;
  logic        err;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pll_coef_calc u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .start_i (start),
    .ref_hz_i(ref_hz),
    .tgt_hz_i(tgt_hz),
    .mode_o  (mode),
    .post_o  (post),
    .n_o     (n_val),
    .k_o     (k_val),
    .done_o  (done),
    .err_o   (err)
  );

  task automatic check(input bit ok, input string msg);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  // expected result from R1/R2/R3/R4/R5/R6
  task automatic expect_of(input longint unsigned r, input longint unsigned t,
                           output bit e_err, output bit e_post, output logic [1:0] e_mode,
                           output longint unsigned e_n, output longint unsigned e_k);
    bit          ps_tab [8]  = '{0, 0, 0, 1, 1, 0, 1, 1};
    logic [1:0]  md_tab [8]  = '{2'b10, 2'b00, 2'b01, 2'b00, 2'b01, 2'b11, 2'b10, 2'b11};
    int          base   [4]  = '{2, 4, 8, 12};
    e_err = 1; e_post = 0; e_mode = 2'b00; e_n = 0; e_k = 0;
    if (r != 0) begin
      for (int i = 0; i < 8; i++) begin
        longint unsigned fac = base[md_tab[i]] * (ps_tab[i] ? 2 : 1);
        longint unsigned f2 = t * fac;
        if (e_err && f2 >= 90_000_000 && f2 <= 100_000_000) begin
          e_err  = 0;
          e_post = ps_tab[i];
          e_mode = md_tab[i];
          e_n    = f2 / r;
          e_k    = ((f2 % r) << 22) / r;
        end
      end
    end
  endtask

  task automatic compare(input longint unsigned r, input longint unsigned t, input string tag);
    bit e_err, e_post;
    logic [1:0] e_mode;
    longint unsigned e_n, e_k;
    expect_of(r, t, e_err, e_post, e_mode, e_n, e_k);
    check(err == e_err && post == e_post && mode == e_mode &&
          longint'(n_val) == e_n && longint'(k_val) == e_k,
          $sformatf("%s ref=%0d tgt=%0d act err=%0d post=%0d mode=%0d n=%0d k=%0d exp err=%0d post=%0d mode=%0d n=%0d k=%0d",
                    tag, r, t, err, post, mode, n_val, k_val, e_err, e_post, e_mode, e_n, e_k));
  endtask

  task automatic wait_done(input string tag);
    int w = 0;
    while (!done && w < 200) begin
      @(negedge clk);
      w++;
    end
    check(done == 1'b1, $sformatf("%s no done act=%0d exp=1", tag, done));
  endtask

  task automatic run_calc(input logic [31:0] r, input logic [31:0] t, input string tag);
    @(negedge clk);
    start = 1; ref_hz = r; tgt_hz = t;
    @(negedge clk);
    start = 0;
    wait_done(tag);
    compare(r, t, tag);
    @(negedge clk);
    check(done == 1'b0, $sformatf("R8 done pulse width act=%0d exp=0", done));
    compare(r, t, "R8 hold");
  endtask

  longint unsigned refs [9] = '{12_000_000, 24_576_000, 27_000_000, 19_200_000,
                                1, 7, 13_000_000, 150_000_000, 0};
  longint unsigned tgts [17] = '{12_288_000, 11_289_600, 45_000_000, 50_000_000,
                                 11_250_000, 12_500_000, 12_500_001, 3_750_000,
                                 4_000_000, 3_700_000, 60_000_000, 0, 23_000_000,
                                 49_999_999, 22_500_000, 6_000_000, 7_500_000};

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(mode == 0 && post == 0 && n_val == 0 && k_val == 0 && done == 0 && err == 0,
          $sformatf("R9 reset act mode=%0d post=%0d n=%0d k=%0d done=%0d err=%0d exp all 0",
                    mode, post, n_val, k_val, done, err));
    rst_n = 1;
    @(negedge clk);

    // R11 worked example
    run_calc(32'd12_000_000, 32'd12_288_000, "R11");
    check(n_val == 27'd8 && k_val == 22'h0C49BA && mode == 2'b10 && post == 1'b0,
          $sformatf("R11 act n=%0d k=%h mode=%0d post=%0d exp n=8 k=0c49ba mode=2 post=0",
                    n_val, k_val, mode, post));

    // sweep over R1 R2 R3 R4 R5 R6
    foreach (refs[i]) begin
      foreach (tgts[j]) begin
        bit e_err, e_post;
        logic [1:0] e_mode;
        longint unsigned e_n, e_k;
        string tag;
        expect_of(refs[i], tgts[j], e_err, e_post, e_mode, e_n, e_k);
        if (refs[i] == 0)  tag = "R6 zero ref";
        else if (e_err)    tag = "R5 no band";
        else               tag = "R1 R2 R3 R4 sweep";
        run_calc(32'(refs[i]), 32'(tgts[j]), tag);
      end
    end

    // R6 latency: done in the very next cycle
    @(negedge clk);
    start = 1; ref_hz = 0; tgt_hz = 32'd12_288_000;
    @(negedge clk);
    start = 0;
    check(done && err, $sformatf("R6 latency act done=%0d err=%0d exp 1 1", done, err));

    // R7 start while busy is ignored
    @(negedge clk);
    start = 1; ref_hz = 32'd24_576_000; tgt_hz = 32'd11_289_600;
    @(negedge clk);
    start = 0;
    repeat (5) @(negedge clk);
    start = 1; ref_hz = 0; tgt_hz = 0;
    @(negedge clk);
    start = 0; ref_hz = 32'd5; tgt_hz = 32'd7;
    repeat (10) @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    wait_done("R7");
    compare(64'd24_576_000, 64'd11_289_600, "R7 busy start ignored");
    begin
      int extra = 0;
      for (int c = 0; c < 80; c++) begin
        @(negedge clk);
        if (done) extra++;
      end
      check(extra == 0, $sformatf("R7 extra done act=%0d exp=0", extra));
      compare(64'd24_576_000, 64'd11_289_600, "R7 R8 hold after");
    end

    // R10 start in done cycle
    @(negedge clk);
    start = 1; ref_hz = 32'd12_000_000; tgt_hz = 32'd7_500_000;
    @(negedge clk);
    start = 0;
    wait_done("R10 first");
    compare(64'd12_000_000, 64'd7_500_000, "R10 first result");
    start = 1; ref_hz = 32'd27_000_000; tgt_hz = 32'd6_000_000;
    @(negedge clk);
    start = 0;
    check(done == 1'b0, $sformatf("R10 done after overlap act=%0d exp=0", done));
    wait_done("R10 second");
    compare(64'd27_000_000, 64'd6_000_000, "R10 second result");

    finished = 1;
    summary();
    $finish;
  end
endmodule